// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This controller connects a simple synchronous request port to an asynchronous 4-bit DRAM whose row and column addresses share one 11-bit address bus. A request carries a 22-bit word address, a read/write flag and 4 bits of write data. It is accepted when `req_valid` and `req_ready` are both high. Reads return their data with a one-cycle `rd_valid` pulse. The controller drives the row strobe, column strobe, write enable, output enable and the address pins. It drives write data on a separate output with its own enable, and it samples read data from a separate input.

After an access the controller leaves the row open. A later request to the same row then runs only a column cycle. A request to a different row first closes the open row and waits out the precharge time, and then activates the new row. A free-running interval counter raises a refresh request. The refresh is served at the next request boundary as a column-strobe-before-row-strobe cycle: any open row is closed first, and requests are held off until the refresh has finished. Every strobe timing is a parameter counted in clock cycles. The defaults are the fast grade at 100 MHz.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: The row address is `req_addr[21:11]` and the column address is `req_addr[10:0]`. The row address is on `dram_addr` when the row strobe falls. The column address is on `dram_addr` when the column strobe falls.
- R3: A read returns, with a single-cycle `rd_valid` pulse, the data last written to that address. The data is sampled no earlier than T_RAC cycles after the row strobe fell, T_CAC cycles after the column strobe fell and T_AA cycles after the column address appeared.
- R4: During a write column cycle, `dram_we_n` is low, `dram_oe_n` is high and `dram_dq_oe` is high with the request's data on `dram_dq_out`, from before the column strobe falls until it rises.
- R5: During a read column cycle, `dram_oe_n` is low, `dram_we_n` is high and `dram_dq_oe` is low.
- R6: A request to the currently open row causes no new row activation: the row strobe stays low, and successive column-strobe falls are at least T_PC cycles apart.
- R7: A request to a different row closes the open row. The row strobe stays low at least T_RC−T_RP cycles and high at least T_RP cycles, and two of its falls are at least T_RC cycles apart.
- R8: A refresh lowers the column strobe while the row strobe is high, lowers the row strobe at least one cycle later, and keeps `dram_we_n` high.
- R9: With T_REFI = 1500, two refreshes are never more than 1562 cycles apart, which is 15.625 µs at 100 MHz. The first refresh after reset also falls within that limit.
- R10: A refresh is still served while requests keep arriving. It leaves no row open, so the next access, even one to the same row, starts with a new row activation.
- R11: Each request is accepted only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after every accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in the upper 11 bits, column in the lower 11 |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 4 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the data drivers |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
The properties assume that `req_addr`, `req_write` and `req_wdata` stay constant while `req_valid` is high and the request has not yet been accepted. They also assume that reset is held long enough for the precharge time to be met before the first activation. The bench drives requests only on falling clock edges and holds every field until it sees `req_ready` at a falling edge and the following rising edge has passed. Its DRAM model returns inverted data whenever a sample is taken before the access times have passed, so an early capture shows up as a read mismatch.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DQ_W   = 4,
  parameter int T_RAC  = 5,
  parameter int T_CAC  = 2,
  parameter int T_AA   = 3,
  parameter int T_PC   = 2,
  parameter int T_RC   = 9,
  parameter int T_RP   = 3,
  parameter int T_REFI = 1500
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in
);
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_CAP = (T_CAC > T_AA - 1) ? T_CAC : T_AA - 1;
  localparam int T_RCD = (T_RAC - T_CAP > 2) ? T_RAC - T_CAP : 2;
  localparam int T_RAS = (T_RC - T_RP > T_RCD + T_CAP + 1) ? T_RC - T_RP : T_RCD + T_CAP + 1;
  localparam int T_CPH = (T_PC - T_CAP - 2 > 1) ? T_PC - T_CAP - 2 : 1;
  localparam int CW    = 8;
  localparam int REF_W = $clog2(T_REFI);

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_CADR, S_COL, S_CP, S_OPEN, S_CLOSE, S_PRE, S_RCAS, S_RRAS
  } state_t;

  state_t            state;
  logic [CW-1:0]     cnt, ras_cnt;
  logic [ROW_W-1:0]  open_row, p_row;
  logic [COL_W-1:0]  p_col;
  logic              p_write, pend, ref_pend;
  logic [DQ_W-1:0]   p_wdata;
  logic [REF_W-1:0]  ref_cnt;

  wire ref_tick = (ref_cnt == REF_W'(T_REFI - 1));
  wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];

  assign req_ready = (state == S_IDLE || state == S_OPEN) && !ref_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      ref_cnt  <= ref_tick ? '0 : ref_cnt + 1'b1;
      ref_pend <= ref_tick | (ref_pend & (state != S_RCAS));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;  cnt <= '0;  ras_cnt <= '0;
      open_row <= '0;  p_row <= '0;  p_col <= '0;
      p_write <= 1'b0;  p_wdata <= '0;  pend <= 1'b0;
      rd_valid <= 1'b0;  rd_data <= '0;
      dram_ras_n <= 1'b1;  dram_cas_n <= 1'b1;
      dram_we_n <= 1'b1;  dram_oe_n <= 1'b1;
      dram_addr <= '0;  dram_dq_out <= '0;  dram_dq_oe <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (!dram_ras_n && ras_cnt != '1) ras_cnt <= ras_cnt + 1'b1;
      case (state)
        S_IDLE:
          if (ref_pend) begin
            dram_cas_n <= 1'b0;
            state      <= S_RCAS;
          end else if (req_valid) begin
            p_row <= req_row;  p_col <= req_addr[COL_W-1:0];
            p_write <= req_write;  p_wdata <= req_wdata;
            dram_ras_n <= 1'b0;  dram_addr <= PIN_W'(req_row);
            ras_cnt <= CW'(1);  open_row <= req_row;
            cnt <= CW'(1);  state <= S_ACT;
          end
        S_ACT:
          if (cnt >= CW'(T_RCD - 1)) begin
            dram_addr   <= PIN_W'(p_col);
            dram_we_n   <= ~p_write;
            dram_oe_n   <= p_write;
            dram_dq_oe  <= p_write;
            dram_dq_out <= p_wdata;
            state       <= S_CADR;
          end else cnt <= cnt + 1'b1;
        S_CADR: begin
          dram_cas_n <= 1'b0;
          cnt        <= CW'(1);
          state      <= S_COL;
        end
        S_COL:
          if (cnt == CW'(T_CAP)) begin
            dram_cas_n <= 1'b1;  dram_we_n <= 1'b1;
            dram_oe_n  <= 1'b1;  dram_dq_oe <= 1'b0;
            if (!p_write) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            cnt   <= CW'(1);
            state <= S_CP;
          end else cnt <= cnt + 1'b1;
        S_CP:
          if (cnt >= CW'(T_CPH)) state <= S_OPEN;
          else cnt <= cnt + 1'b1;
        S_OPEN:
          if (ref_pend) state <= S_CLOSE;
          else if (req_valid) begin
            p_row <= req_row;  p_col <= req_addr[COL_W-1:0];
            p_write <= req_write;  p_wdata <= req_wdata;
            if (req_row == open_row) begin
              cnt   <= CW'(T_RCD - 1);
              state <= S_ACT;
            end else begin
              pend  <= 1'b1;
              state <= S_CLOSE;
            end
          end
        S_CLOSE:
          if (ras_cnt >= CW'(T_RAS)) begin
            dram_ras_n <= 1'b1;
            cnt        <= CW'(1);
            state      <= S_PRE;
          end
        S_PRE:
          if (cnt >= CW'(T_RP)) begin
            if (ref_pend) begin
              dram_cas_n <= 1'b0;
              state      <= S_RCAS;
            end else if (pend) begin
              pend <= 1'b0;
              dram_ras_n <= 1'b0;  dram_addr <= PIN_W'(p_row);
              ras_cnt <= CW'(1);  open_row <= p_row;
              cnt <= CW'(1);  state <= S_ACT;
            end else state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        S_RCAS: begin
          dram_ras_n <= 1'b0;
          ras_cnt    <= CW'(1);
          state      <= S_RRAS;
        end
        S_RRAS:
          if (ras_cnt >= CW'(T_RAS)) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            cnt        <= CW'(1);
            state      <= S_PRE;
          end
        default: state <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RP = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_cnt <= '1;
    else if (!dram_ras_n) hi_cnt <= '0;
    else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R4
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && !dram_cas_n && !dram_we_n) |-> (dram_dq_oe && dram_oe_n));

  // R5
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && !dram_cas_n && !dram_oe_n) |-> (dram_we_n && !dram_dq_oe));

  // R7
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= 16'(T_RP)));

  // R8
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int T_RAC = 5, T_CAC = 2, T_AA = 3, T_PC = 2, T_RC = 9, T_RP = 3;
  localparam int T_RAS_MIN = T_RC - T_RP;
  localparam int REF_LIMIT = 1562;
  localparam int NV = 14;
  // {write, row, col, data}; for reads the data field is the expected value
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 11'h005, 11'h001, 4'hA},
    {1'b1, 11'h005, 11'h7FF, 4'h5},
    {1'b1, 11'h7FF, 11'h000, 4'h3},
    {1'b1, 11'h000, 11'h123, 4'hC},
    {1'b0, 11'h005, 11'h001, 4'hA},
    {1'b0, 11'h005, 11'h7FF, 4'h5},
    {1'b0, 11'h7FF, 11'h000, 4'h3},
    {1'b0, 11'h000, 11'h123, 4'hC},
    {1'b1, 11'h000, 11'h123, 4'hF},
    {1'b0, 11'h000, 11'h123, 4'hF},
    {1'b1, 11'h2AA, 11'h155, 4'h6},
    {1'b1, 11'h400, 11'h400, 4'h9},
    {1'b0, 11'h2AA, 11'h155, 4'h6},
    {1'b0, 11'h400, 11'h400, 4'h9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [3:0]  rd_data;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [10:0] dram_addr;
  logic [3:0]  dram_dq_out;
  logic [3:0]  dq_in = '0;

  always #5 clk = ~clk;

  fpm_dram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dq_in)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // DRAM model and strobe timing monitor
  logic [3:0] mem [int];
  int cyc = 0, t_rf = -100, t_rr = -100, t_cf = -100, t_adr = -100, last_ref = 0;
  int nact = 0, nref = 0, ncol = 0;
  bit pr = 1'b1, pc = 1'b1, col_in_row = 1'b0;
  logic [10:0] pa = '0, cur_row = '0;
  logic [21:0] exp_addr = '0;
  logic [3:0]  exp_wdata = '0;

  always @(negedge clk) begin
    int key;
    bit ok;
    cyc++;
    if (rst_n) begin
      if (pa != dram_addr) t_adr = cyc;
      if (pr && !dram_ras_n) begin
        chk(cyc - t_rr >= T_RP, "R7 row strobe high time", cyc - t_rr, T_RP);
        chk(cyc - t_rf >= T_RC, "R7 row cycle time", cyc - t_rf, T_RC);
        if (!dram_cas_n) begin
          chk(!pc && dram_we_n, "R8 column strobe before row strobe", {pc, dram_we_n}, 1);
          chk(cyc - last_ref <= REF_LIMIT, "R9 refresh spacing", cyc - last_ref, REF_LIMIT);
          last_ref = cyc;
          nref++;
        end else begin
          nact++;
          cur_row = dram_addr;
        end
        col_in_row = 1'b0;
        t_rf = cyc;
      end
      if (!pr && dram_ras_n) begin
        chk(cyc - t_rf >= T_RAS_MIN, "R7 row strobe low time", cyc - t_rf, T_RAS_MIN);
        t_rr = cyc;
      end
      if (pc && !dram_cas_n && !dram_ras_n) begin
        chk({cur_row, dram_addr} == exp_addr, "R2 row/column address split",
            {cur_row, dram_addr}, exp_addr);
        if (col_in_row)
          chk(cyc - t_cf >= T_PC, "R6 page cycle time", cyc - t_cf, T_PC);
        if (!dram_we_n) begin
          chk(dram_dq_oe && dram_oe_n && dram_dq_out == exp_wdata, "R4 write drive",
              {dram_dq_oe, dram_oe_n, dram_dq_out}, {2'b11, exp_wdata});
          mem[int'({cur_row, dram_addr})] = dram_dq_out;
        end else begin
          chk(!dram_dq_oe && !dram_oe_n, "R5 read enables", {dram_dq_oe, dram_oe_n}, 0);
        end
        col_in_row = 1'b1;
        t_cf = cyc;
        ncol++;
      end
    end
    pr = dram_ras_n;
    pc = dram_cas_n;
    pa = dram_addr;
    key = int'({cur_row, dram_addr});
    ok = (cyc + 1 - t_rf >= T_RAC) && (cyc + 1 - t_cf >= T_CAC) && (cyc + 1 - t_adr >= T_AA);
    if (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n && mem.exists(key))
      dq_in = ok ? mem[key] : ~mem[key];
    else
      dq_in = 4'h0;
  end

  task automatic do_req(input bit w, input logic [21:0] a, input logic [3:0] d,
                        output logic [3:0] rdat);
    int n0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    exp_addr = a; exp_wdata = d;
    while (!req_ready) @(negedge clk);
    n0 = ncol;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 ready low after accept", req_ready, 0);
    rdat = 4'h0;
    if (w) begin
      while (ncol == n0) @(negedge clk);
    end else begin
      while (!rd_valid) @(negedge clk);
      rdat = rd_data;
      @(negedge clk);
      chk(!rd_valid, "R3 single-cycle valid", rd_valid, 0);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [3:0] r;
    int a0, r0;
    repeat (5) @(negedge clk);
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid} == 6'b111100,
        "R1 outputs in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid},
        6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid, req_ready} == 7'b1111001,
        "R1 outputs after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid, req_ready}, 7'b1111001);

    for (int i = 0; i < NV; i++) begin
      do_req(VEC[i][26], VEC[i][25:4], VEC[i][3:0], r);
      if (!VEC[i][26]) chk(r == VEC[i][3:0], "R3 read data", r, VEC[i][3:0]);
    end

    // R6: same-row access adds no activation
    do_req(1'b0, {11'h005, 11'h001}, 4'h0, r);
    a0 = nact;
    do_req(1'b0, {11'h005, 11'h7FF}, 4'h0, r);
    chk(nact == a0, "R6 page hit without activation", nact, a0);
    chk(r == 4'h5, "R6 page hit data", r, 4'h5);

    // R7: different row forces one activation
    do_req(1'b0, {11'h7FF, 11'h000}, 4'h0, r);
    chk(nact == a0 + 1, "R7 row miss activation", nact, a0 + 1);
    chk(r == 4'h3, "R7 row miss data", r, 4'h3);

    // R9/R10: idle with a row open, then same-row access
    do_req(1'b0, {11'h000, 11'h123}, 4'h0, r);
    r0 = nref;
    a0 = nact;
    repeat (1700) @(negedge clk);
    chk(nref > r0, "R9 refresh while idle", nref, r0 + 1);
    do_req(1'b0, {11'h000, 11'h123}, 4'h0, r);
    chk(nact == a0 + 1, "R10 row reopened after refresh", nact, a0 + 1);
    chk(r == 4'hF, "R10 data after refresh", r, 4'hF);

    // R10: refresh is served amid continuous traffic
    r0 = nref;
    for (int k = 0; k < 260; k++) begin
      do_req(1'b0, (k % 3 == 0) ? {11'h2AA, 11'h155} : {11'h005, 11'h001}, 4'h0, r);
      chk(r == ((k % 3 == 0) ? 4'h6 : 4'hA), "R10 read under traffic", r,
          (k % 3 == 0) ? 4'h6 : 4'hA);
    end
    chk(nref > r0, "R10 refresh not starved", nref, r0 + 1);

    @(negedge clk);
    chk(cyc - last_ref <= REF_LIMIT, "R9 final refresh spacing", cyc - last_ref, REF_LIMIT);
    done = 1'b1;
    finish_run();
  end
endmodule